// File: doc/BRIEF.md
# Differential PSK Dibit Decoder

This block turns a stream of quantized carrier phases, one per symbol, into data bits for differential binary and differential quadrature phase-shift keying. Each symbol arrives as a 2-bit quadrant index, where index q stands for q times 90 degrees of counterclockwise rotation. It comes with a valid strobe. The block forms the phase change from the previously accepted symbol and maps that change to one bit in binary mode or to a pair of bits in quadrature mode. Only the change carries data, so the absolute carrier phase does not matter.

Bits leave the block one per cycle with a valid strobe, earliest in time first. A quadrature symbol yields two bits on consecutive cycles. While the second bit is pending, the block lowers its ready output. A configuration input reverses the sense of rotation. A sync input discards the phase reference, so that the next symbol only seeds it. Each output depends on two successive phase decisions, so one wrong decision spoils two decoded symbols.

Top module: `dpsk_dibit_decoder`

## Requirements
- R1: After reset `bit_valid` is 0, `in_ready` is 1 and no phase reference is held.
- R2: The first symbol accepted after reset, or after a `sync` pulse without `phase_valid`, only stores the reference and produces no output bit.
- R3: The phase change is (current index - reference index) mod 4. Every accepted symbol becomes the new reference, so a continuous stream is decoded pairwise.
- R4: With `mode_qpsk`=0 one bit is output: a change of 0 or +90 degrees (index 0 or 1) gives 0, and a change of 180 or -90 degrees (index 2 or 3) gives 1.
- R5: With `mode_qpsk`=1 the change maps to a pair of bits written first-second: 0 deg gives 00, +90 gives 01, 180 gives 11, and -90 gives 10. The left bit is emitted first.
- R6: With `rot_reverse`=1 the phase change is negated mod 4 before the mapping.
- R7: The first bit of an accepted symbol appears on `bit_out` with `bit_valid` in the cycle after acceptance. In quadrature mode the second bit follows in the next cycle, and `in_ready` is 0 during the first-bit cycle.
- R8: `phase_valid` while `in_ready` is 0 is ignored: no bit is produced and the reference is unchanged.
- R9: A symbol accepted in the same cycle as `sync` becomes the new reference and produces no output bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync | input | 1 | Discard phase reference |
| phase_in | input | 2 | Quadrant index of the symbol |
| phase_valid | input | 1 | Symbol present |
| mode_qpsk | input | 1 | 1: two bits per symbol, 0: one bit |
| rot_reverse | input | 1 | Negate the sense of rotation |
| in_ready | output | 1 | Symbol can be accepted |
| bit_out | output | 1 | Decoded bit |
| bit_valid | output | 1 | bit_out holds a bit |

## Verification
The bench sweeps every pair of reference and current quadrant, in both modes and both rotation senses. Each pair is seeded by a sync load, so every row of the change-to-bits mapping is seen. A wrong quadrant index or a swapped bit order shows up as a mismatch in a named cell of that sweep. A long unsynchronized stream checks that the reference advances with each symbol. It tells pairwise decoding apart from decoding against the first symbol. Symbols offered while ready is low, and sync pulses with and without a symbol, separate a reference that is held correctly from one that is overwritten or reseeded.

// File: rtl/dpsk_pkg.sv
package dpsk_pkg;
  localparam int QUAD_W = 2;
  localparam int NQUAD  = 1 << QUAD_W;

  typedef logic [QUAD_W-1:0] quad_t;

  // Phase change in quadrants, optionally with the rotation sense reversed.
  function automatic quad_t phase_delta(input quad_t cur, input quad_t prev,
                                        input logic rev);
    quad_t d;
    d = quad_t'(cur - prev);
    if (rev) d = quad_t'(-d);
    return d;
  endfunction

  // Gray-style pair: first-in-time bit is the half-turn bit.
  function automatic logic [1:0] pair_of(input quad_t d);
    return {d[QUAD_W-1], d[QUAD_W-1] ^ d[0]};
  endfunction

  // Single-bit decision: quarter turns lean to the neighbour on their side.
  function automatic logic single_of(input quad_t d);
    return d[QUAD_W-1];
  endfunction
endpackage

// File: rtl/dpsk_phase_ref.sv
module dpsk_phase_ref
  import dpsk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sync,
  input  logic  accept,
  input  quad_t phase_in,
  input  logic  rot_reverse,
  output logic  fire,
  output logic  ref_loaded,
  output quad_t delta
);
  quad_t ref_phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_phase  <= '0;
      ref_loaded <= 1'b0;
    end else if (accept) begin
      ref_phase  <= phase_in;
      ref_loaded <= 1'b1;
    end else if (sync) begin
      ref_loaded <= 1'b0;
    end
  end

  assign fire  = accept && ref_loaded && !sync;
  assign delta = phase_delta(phase_in, ref_phase, rot_reverse);

  // R8: reference changes only on an accepted symbol
  a_r8_ref_held: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(ref_phase));
  // R9: a symbol with sync leaves a valid reference
  a_r9_sync_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sync) |=> ref_loaded);
endmodule

// File: rtl/dpsk_mapper.sv
module dpsk_mapper
  import dpsk_pkg::*;
(
  input  quad_t      delta,
  input  logic       mode_qpsk,
  output logic [1:0] bits
);
  always_comb begin
    if (mode_qpsk) bits = pair_of(delta);
    else           bits = {single_of(delta), 1'b0};
  end
endmodule

// File: rtl/dpsk_serializer.sv
module dpsk_serializer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       two,
  input  logic [1:0] bits,
  output logic       in_ready,
  output logic       bit_out,
  output logic       bit_valid
);
  logic pending, pend_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      pend_bit  <= 1'b0;
      bit_out   <= 1'b0;
      bit_valid <= 1'b0;
    end else if (load) begin
      bit_valid <= 1'b1;
      bit_out   <= bits[1];
      pending   <= two;
      pend_bit  <= bits[0];
    end else if (pending) begin
      bit_valid <= 1'b1;
      bit_out   <= pend_bit;
      pending   <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
    end
  end

  assign in_ready = !pending;

  // R7: a loaded symbol always yields a bit next cycle
  a_r7_load_emits: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> bit_valid);
  // R7: a held-off cycle carries a bit and releases next cycle
  a_r7_pending_drains: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (bit_valid && in_ready));
endmodule

// File: rtl/dpsk_dibit_decoder.sv
module dpsk_dibit_decoder
  import dpsk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync,
  input  logic [1:0] phase_in,
  input  logic       phase_valid,
  input  logic       mode_qpsk,
  input  logic       rot_reverse,
  output logic       in_ready,
  output logic       bit_out,
  output logic       bit_valid
);
  logic       accept, fire, ref_loaded;
  quad_t      delta;
  logic [1:0] bits;

  assign accept = phase_valid && in_ready;

  dpsk_phase_ref i_ref (
    .clk, .rst_n, .sync, .accept, .phase_in, .rot_reverse,
    .fire, .ref_loaded, .delta
  );

  dpsk_mapper i_map (.delta, .mode_qpsk, .bits);

  dpsk_serializer i_ser (
    .clk, .rst_n, .load(fire), .two(mode_qpsk), .bits,
    .in_ready, .bit_out, .bit_valid
  );

  // R2: a seeding symbol produces no bit
  a_r2_seed_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ref_loaded) |=> !bit_valid);
  // R9: symbol with sync produces no bit
  a_r9_sync_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sync) |=> !bit_valid);
  // R5: quadrature symbol holds off the input for its second bit
  a_r5_pair_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode_qpsk) |=> !in_ready);
  // R4: binary symbol leaves the input open
  a_r4_single_open: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !mode_qpsk) |=> in_ready);
endmodule

// File: tb/test_dpsk_dibit_decoder.sv
`timescale 1ns/1ps
module test_dpsk_dibit_decoder;
  logic clk = 1'b0, rst_n = 1'b0, sync = 1'b0, phase_valid = 1'b0;
  logic mode_qpsk = 1'b0, rot_reverse = 1'b0;
  logic [1:0] phase_in = 2'd0;
  logic in_ready, bit_out, bit_valid;
  int checks = 0, errors = 0;
  int got_n;
  logic [1:0] got;

  always #2 clk = ~clk;

  dpsk_dibit_decoder i_dpsk_dibit_decoder (
    .clk, .rst_n, .sync, .phase_in, .phase_valid, .mode_qpsk, .rot_reverse,
    .in_ready, .bit_out, .bit_valid
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected change in quadrants, computed as degrees.
  function automatic int exp_step(int prev, int cur, bit rev);
    int deg;
    deg = ((cur - prev) * 90 + 360) % 360;
    if (rev) deg = (360 - deg) % 360;
    return deg / 90;
  endfunction

  // Expected bits packed as first*2+second (qpsk) or bit (bpsk).
  function automatic int exp_bits(int step, bit q);
    if (!q) return (step >= 2) ? 1 : 0;
    case (step)
      0: return 0;
      1: return 1;
      2: return 3;
      default: return 2;
    endcase
  endfunction

  // Offer one symbol, collect the bits that follow.
  task automatic send(input int ph, input bit q, input bit rev, input bit sy);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    phase_in = 2'(ph); mode_qpsk = q; rot_reverse = rev;
    phase_valid = 1'b1; sync = sy;
    @(negedge clk);
    phase_valid = 1'b0; sync = 1'b0;
    got_n = 0; got = 2'b00;
    if (bit_valid) begin
      got_n = 1; got[1] = bit_out;
      if (q) begin
        check("R7 in_ready low in first-bit cycle", int'(in_ready), 0);
        @(negedge clk);
        if (bit_valid) begin got_n = 2; got[0] = bit_out; end
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int prev;
    repeat (3) @(negedge clk);
    check("R1 bit_valid after reset", int'(bit_valid), 0);
    check("R1 in_ready after reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 bit_valid idle", int'(bit_valid), 0);

    // R2: very first symbol only seeds
    send(2, 1'b1, 1'b0, 1'b0);
    check("R2 first symbol no bits", got_n, 0);

    // Sweep all reference/current pairs, modes and senses.
    for (int q = 0; q < 2; q++)
      for (int rv = 0; rv < 2; rv++)
        for (int p = 0; p < 4; p++)
          for (int c = 0; c < 4; c++) begin
            int e;
            send(p, q[0], rv[0], 1'b1);
            check("R9 sync symbol no bits", got_n, 0);
            send(c, q[0], rv[0], 1'b0);
            e = exp_bits(exp_step(p, c, rv[0]), q[0]);
            if (q == 1) begin
              check("R7 two bits", got_n, 2);
              check(rv ? "R6 reversed pair" : "R5 pair", int'(got), e);
            end else begin
              check("R7 one bit", got_n, 1);
              check(rv ? "R6 reversed bit" : "R4 bit", int'(got[1]), e);
            end
          end

    // R3: a continuous stream decodes each symbol against the previous one.
    prev = 0;
    send(0, 1'b1, 1'b0, 1'b1);
    for (int k = 1; k < 40; k++) begin
      int c;
      c = (k * 3 + k / 5) % 4;
      send(c, 1'b1, 1'b0, 1'b0);
      check("R3 stream pair", int'(got), exp_bits(exp_step(prev, c, 1'b0), 1'b1));
      prev = c;
    end

    // R2: sync alone drops the reference; next symbol seeds only.
    @(negedge clk); sync = 1'b1;
    @(negedge clk); sync = 1'b0;
    check("R2 sync alone no bits", int'(bit_valid), 0);
    send(1, 1'b0, 1'b0, 1'b0);
    check("R2 seed after sync no bits", got_n, 0);
    send(3, 1'b0, 1'b0, 1'b0);
    check("R2 decode after reseed", int'(got[1]), 1);

    // R8: symbol offered while in_ready is low is ignored.
    send(0, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    phase_in = 2'd1; mode_qpsk = 1'b1; phase_valid = 1'b1;
    @(negedge clk);
    check("R8 first bit present", int'(bit_valid), 1);
    check("R8 in_ready low", int'(in_ready), 0);
    phase_in = 2'd3;
    @(negedge clk);
    phase_valid = 1'b0;
    check("R8 second bit present", int'(bit_valid), 1);
    @(negedge clk);
    check("R8 nothing from ignored symbol", int'(bit_valid), 0);
    send(2, 1'b1, 1'b0, 1'b0);
    check("R8 reference kept", int'(got), exp_bits(exp_step(1, 2, 1'b0), 1'b1));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule